// File: doc/BRIEF.md
# Quad-Burst Shared Bus Memory Slave

This block is the memory-side responder on a synchronous bus. One 32-bit path carries addresses and data in turn, and a command field says what the current master wants. The master places a command and an address in cycle 0. The slave then runs one transaction to its end before it looks at the command field again.

The slave holds two storage areas: a word-addressed memory array and a small bank of I/O registers. Each is reached through its own 32-bit physical address space. Quad reads return the word that was asked for first, then wrap around inside the aligned group of four words. Quad writes take four ascending words into a buffer and acknowledge once, after the last one. Single-word I/O accesses can be stretched by wait states. A broadcast single-word write takes up two bus cycles, but the slave stores nothing from it.

A configuration input, sampled together with the command, sets the number of wait states for each transaction. A quad write to an address that is not a multiple of four sets a sticky error flag. That write's data is thrown away, but the bus handshake still completes.

Top module: `quad_bus_slave`

## Requirements
- R1: After reset, rdy_o, ad_oe_o, ad_o and align_err_o are all 0, and every memory word and I/O register reads as 0.
- R2: For a quad read (cmd 1) issued in cycle 0 with wait count w, rdy_o and ad_oe_o are 0 during cycles 1..w. In cycle w+1 both are 1 and ad_o carries the word at the requested address. Whenever ad_oe_o is 0, ad_o is 0.
- R3: In cycles w+2, w+3 and w+4 of a quad read, ad_oe_o stays 1 and rdy_o is 0. ad_o carries the words at offsets (a+1) mod 4, (a+2) mod 4 and (a+3) mod 4 of the aligned quad that holds address a.
- R4: For a quad write (cmd 2) to an address a that is a multiple of 4, the data presented in cycles 1, 2, 3 and 4 is stored at a, a+1, a+2 and a+3. rdy_o is high only in cycle 4+w, for exactly one cycle.
- R5: A quad write whose address has a nonzero remainder mod 4 stores nothing. It still gives rdy_o in cycle 4+w, and it sets align_err_o from cycle 1 onward. Only reset clears align_err_o.
- R6: An I/O read (cmd 4) returns the addressed I/O register on ad_o with rdy_o and ad_oe_o high in cycle w+1, and low in every other cycle of the transaction.
- R7: An I/O write (cmd 5) stores the data from cycle 1 into the addressed I/O register and raises rdy_o only in cycle 1+w. An I/O write never changes the memory array, and a quad write never changes an I/O register.
- R8: A broadcast write (cmd 3) takes cycles 0 and 1. It raises neither rdy_o nor ad_oe_o, and it leaves memory unchanged.
- R9: Commands that arrive before a transaction ends have no effect. The slave accepts a new command in the cycle after the last cycle of the previous transaction: cycle w+5 after a quad read, cycle w+2 after an I/O read, the cycle after rdy_o after a write, and cycle 2 after a broadcast.
- R10: The memory index is the address modulo MEM_WORDS (64 by default). The I/O index is the I/O address modulo IO_WORDS (8 by default). Addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 0 none, 1 quad read, 2 quad write, 3 broadcast write, 4 I/O read, 5 I/O write |
| ad_i | input | 32 | Address in cycle 0, write data in the data cycles |
| wait_i | input | WAIT_W | Wait states for the command in cycle 0 |
| ad_o | output | 32 | Read data driven by the slave, 0 when not driving |
| ad_oe_o | output | 1 | Slave is driving read data |
| rdy_o | output | 1 | Ready or done response for the current transaction |
| align_err_o | output | 1 | Sticky flag set by a misaligned quad write |

## Verification
The bench starts quad reads at every offset within a quad, with zero, one and three wait states. A design that wrapped the burst wrongly, or walked past the quad boundary, would put a wrong word on ad_o in the three trailing cycles. Writes are run with zero, one and two wait states to pin the acknowledge to the right cycle. An acknowledge one cycle early or late shows up as a mismatch on rdy_o, and an I/O write that kept the wrong beat of data shows up on the next I/O read. During long transactions the bench drives write and I/O commands into the busy cycles, and a broadcast is aimed at a stored quad. A design that accepted either would corrupt words that are read back later. Aliased addresses and same-numbered addresses in the two spaces catch a wrong index width, or storage shared between the spaces.

// File: rtl/quad_bus_slave.sv
module quad_bus_slave #(
  parameter int MEM_WORDS = 64,
  parameter int IO_WORDS  = 8,
  parameter int WAIT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [31:0]       ad_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [31:0]       ad_o,
  output logic              ad_oe_o,
  output logic              rdy_o,
  output logic              align_err_o
);
  localparam int MAW = $clog2(MEM_WORDS);
  localparam int IAW = (IO_WORDS > 1) ? $clog2(IO_WORDS) : 1;
  localparam int AQW = (MAW > IAW) ? MAW : IAW;

  localparam logic [2:0] C_RDQ  = 3'd1;
  localparam logic [2:0] C_WRQ  = 3'd2;
  localparam logic [2:0] C_BC   = 3'd3;
  localparam logic [2:0] C_IORD = 3'd4;
  localparam logic [2:0] C_IOWR = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_RWAIT, S_RDAT, S_IOEND, S_WDAT, S_IOWD, S_WACK, S_WEND, S_BC
  } st_t;

  st_t               st;
  logic [WAIT_W-1:0] cnt, w_q;
  logic [AQW-1:0]    a_q;
  logic [2:0]        beat;
  logic              is_io, bad_q;
  logic [31:0]       buf_q [3];
  logic [31:0]       mem [MEM_WORDS];
  logic [31:0]       iom [IO_WORDS];
  logic              rdy_q, oe_q, err_q;
  logic [31:0]       do_q;

  // acknowledge tail shared by both write kinds
  st_t               tail_st;
  logic              tail_rdy;
  logic [WAIT_W-1:0] tail_cnt;
  always_comb begin
    tail_cnt = '0;
    if (w_q == '0) begin
      tail_st = S_IDLE; tail_rdy = 1'b0;
    end else if (w_q == WAIT_W'(1)) begin
      tail_st = S_WEND; tail_rdy = 1'b1;
    end else begin
      tail_st = S_WACK; tail_rdy = 1'b0; tail_cnt = w_q - WAIT_W'(2);
    end
  end

  wire [MAW-1:0] rd_idx  = {a_q[MAW-1:2], 2'(a_q[1:0] + beat[1:0])};
  wire [MAW-1:0] in_midx = ad_i[MAW-1:0];
  wire [IAW-1:0] in_iidx = ad_i[IAW-1:0];
  wire [MAW-1:0] q_midx  = a_q[MAW-1:0];
  wire [IAW-1:0] q_iidx  = a_q[IAW-1:0];
  wire [MAW-3:0] q_quad  = a_q[MAW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; w_q <= '0; a_q <= '0; beat <= '0;
      is_io <= 1'b0; bad_q <= 1'b0;
      rdy_q <= 1'b0; oe_q <= 1'b0; err_q <= 1'b0; do_q <= '0;
      for (int i = 0; i < 3; i++) buf_q[i] <= '0;
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
      for (int i = 0; i < IO_WORDS; i++) iom[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          rdy_q <= 1'b0; oe_q <= 1'b0; do_q <= '0;
          a_q <= ad_i[AQW-1:0]; w_q <= wait_i; beat <= 3'd1;
          case (cmd_i)
            C_RDQ, C_IORD: begin
              is_io <= (cmd_i == C_IORD);
              if (wait_i == '0) begin
                rdy_q <= 1'b1; oe_q <= 1'b1;
                do_q  <= (cmd_i == C_IORD) ? iom[in_iidx] : mem[in_midx];
                st    <= (cmd_i == C_IORD) ? S_IOEND : S_RDAT;
              end else begin
                cnt <= wait_i - WAIT_W'(1);
                st  <= S_RWAIT;
              end
            end
            C_WRQ: begin
              bad_q <= (ad_i[1:0] != 2'd0);
              if (ad_i[1:0] != 2'd0) err_q <= 1'b1;
              beat <= 3'd0;
              st   <= S_WDAT;
            end
            C_IOWR: begin
              rdy_q <= (wait_i == '0);
              st    <= S_IOWD;
            end
            C_BC: st <= S_BC;
            default: ;
          endcase
        end
        S_RWAIT: begin
          if (cnt == '0) begin
            rdy_q <= 1'b1; oe_q <= 1'b1;
            do_q  <= is_io ? iom[q_iidx] : mem[q_midx];
            st    <= is_io ? S_IOEND : S_RDAT;
          end else begin
            cnt <= cnt - WAIT_W'(1);
          end
        end
        S_RDAT: begin
          rdy_q <= 1'b0;
          if (beat == 3'd4) begin
            oe_q <= 1'b0; do_q <= '0; st <= S_IDLE;
          end else begin
            do_q <= mem[rd_idx];
            beat <= beat + 3'd1;
          end
        end
        S_IOEND: begin
          rdy_q <= 1'b0; oe_q <= 1'b0; do_q <= '0; st <= S_IDLE;
        end
        S_WDAT: begin
          if (beat == 3'd3) begin
            if (!bad_q) begin
              for (int k = 0; k < 3; k++) mem[{q_quad, 2'(k)}] <= buf_q[k];
              mem[{q_quad, 2'd3}] <= ad_i;
            end
            rdy_q <= tail_rdy; cnt <= tail_cnt; st <= tail_st;
          end else begin
            buf_q[beat[1:0]] <= ad_i;
            beat  <= beat + 3'd1;
            rdy_q <= (beat == 3'd2) && (w_q == '0);
          end
        end
        S_IOWD: begin
          iom[q_iidx] <= ad_i;
          rdy_q <= tail_rdy; cnt <= tail_cnt; st <= tail_st;
        end
        S_WACK: begin
          if (cnt == '0) begin
            rdy_q <= 1'b1; st <= S_WEND;
          end else begin
            cnt <= cnt - WAIT_W'(1);
          end
        end
        S_WEND: begin
          rdy_q <= 1'b0; st <= S_IDLE;
        end
        S_BC: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ad_o        = do_q;
  assign ad_oe_o     = oe_q;
  assign rdy_o       = rdy_q;
  assign align_err_o = err_q;

  p_rdy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |=> align_err_o);
  p_misalign_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_i == C_WRQ && ad_i[1:0] != 2'd0) |=> align_err_o);
  p_bcast_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_i == C_BC) |=> (!rdy_o && !ad_oe_o));
  p_burst_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDAT && beat != 3'd4) |=> (ad_oe_o && !rdy_o));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!rdy_o && !ad_oe_o));
  p_zero_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_o |-> (ad_o == 32'd0));
endmodule

// File: tb/quad_bus_slave_tb.sv
`timescale 1ns/1ps
module quad_bus_slave_tb;
  localparam int MW = 64;
  localparam int IW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [31:0] ad_i = '0;
  logic [3:0]  wait_i = '0;
  logic [31:0] ad_o;
  logic        ad_oe_o, rdy_o, align_err_o;

  quad_bus_slave #(.MEM_WORDS(MW), .IO_WORDS(IW), .WAIT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ad_i(ad_i), .wait_i(wait_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .rdy_o(rdy_o), .align_err_o(align_err_o));

  always #2.5 clk = ~clk;

  logic [31:0] mem_m [MW];
  logic [31:0] io_m [IW];
  logic        err_m = 1'b0;
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one bus cycle: compare this cycle's outputs, then present inputs
  task automatic step(input logic [2:0] c, input logic [31:0] d, input logic [3:0] w,
                      input logic er, input logic eo, input logic [31:0] ed, input string req);
    logic [31:0] xd;
    @(negedge clk);
    xd = eo ? ed : 32'd0;
    checks++;
    if (rdy_o !== er || ad_oe_o !== eo || ad_o !== xd || align_err_o !== err_m) begin
      errors++;
      $display("FAIL %s: rdy=%b oe=%b ad=%h err=%b expected rdy=%b oe=%b ad=%h err=%b",
               req, rdy_o, ad_oe_o, ad_o, align_err_o, er, eo, xd, err_m);
    end
    cmd_i = c; ad_i = d; wait_i = w;
  endtask

  task automatic rdq(input logic [31:0] a, input int w, input logic [2:0] jc, input logic [31:0] ja);
    int ix, base;
    ix = a % MW; base = ix & ~3;
    step(3'd1, a, 4'(w), 0, 0, 0, "R9");
    for (int i = 0; i < w; i++) step(jc, ja, 4'd0, 0, 0, 0, "R2");
    step(jc, ja, 4'd0, 1, 1, mem_m[ix], "R2");
    for (int k = 1; k < 4; k++) step(jc, ja, 4'd0, 0, 1, mem_m[base + ((ix + k) % 4)], "R3");
  endtask

  task automatic wrq(input logic [31:0] a, input logic [31:0] d0, input logic [31:0] d1,
                     input logic [31:0] d2, input logic [31:0] d3, input int w, input logic [2:0] jc);
    logic [31:0] dv [4];
    int ix;
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    step(3'd2, a, 4'(w), 0, 0, 0, "R9");
    if (a % 4 != 0) err_m = 1'b1;
    for (int c = 1; c <= 4 + w; c++)
      step(jc, (c <= 4) ? dv[c-1] : 32'd0, 4'd0, (c == 4 + w), 0, 0, (a % 4 != 0) ? "R5" : "R4");
    if (a % 4 == 0) begin
      ix = a % MW;
      for (int k = 0; k < 4; k++) mem_m[ix + k] = dv[k];
    end
  endtask

  task automatic iord(input logic [31:0] a, input int w);
    step(3'd4, a, 4'(w), 0, 0, 0, "R9");
    for (int i = 0; i < w; i++) step(3'd5, a, 4'd0, 0, 0, 0, "R6");
    step(3'd0, 0, 4'd0, 1, 1, io_m[a % IW], "R6");
  endtask

  task automatic iowr(input logic [31:0] a, input logic [31:0] d, input int w);
    step(3'd5, a, 4'(w), 0, 0, 0, "R9");
    for (int c = 1; c <= 1 + w; c++)
      step(3'd2, (c == 1) ? d : 32'hDEAD0000, 4'd0, (c == 1 + w), 0, 0, "R7");
    io_m[a % IW] = d;
  endtask

  initial begin
    for (int i = 0; i < MW; i++) mem_m[i] = '0;
    for (int i = 0; i < IW; i++) io_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(3'd0, 0, 0, 0, 0, 0, "R1");
    step(3'd0, 0, 0, 0, 0, 0, "R1");
    rdq(32'h10, 0, 3'd0, 0);
    iord(32'h3, 0);
    // R4 / R3 / R2
    wrq(32'h20, 32'hA0, 32'hA1, 32'hA2, 32'hA3, 0, 3'd0);
    rdq(32'h22, 0, 3'd0, 0);
    rdq(32'h23, 3, 3'd0, 0);
    rdq(32'h21, 1, 3'd0, 0);
    wrq(32'h44, 32'hB0, 32'hB1, 32'hB2, 32'hB3, 2, 3'd0);
    rdq(32'h45, 1, 3'd0, 0);
    wrq(32'h08, 32'hC0, 32'hC1, 32'hC2, 32'hC3, 1, 3'd0);
    rdq(32'h0B, 0, 3'd0, 0);
    // R5 misaligned write discarded
    wrq(32'h31, 32'hE0, 32'hE1, 32'hE2, 32'hE3, 1, 3'd0);
    rdq(32'h30, 0, 3'd0, 0);
    step(3'd0, 0, 0, 0, 0, 0, "R5");
    // R6 / R7 / R10 I/O
    iowr(32'h5, 32'h1234_5678, 0);
    iowr(32'h12, 32'h0BAD_F00D, 3);
    iord(32'h5, 0);
    iord(32'hA, 2);
    rdq(32'h04, 0, 3'd0, 0);
    // R8 broadcast ignored
    step(3'd3, 32'h20, 0, 0, 0, 0, "R8");
    step(3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
    rdq(32'h20, 0, 3'd0, 0);
    // R9 commands during busy cycles ignored
    rdq(32'h46, 2, 3'd2, 32'h20);
    rdq(32'h20, 0, 3'd0, 0);
    wrq(32'h0C, 32'hD0, 32'hD1, 32'hD2, 32'hD3, 2, 3'd5);
    iord(32'h0, 0);
    iord(32'h5, 1);
    rdq(32'h0D, 0, 3'd0, 0);
    // R10 aliasing
    rdq(32'h60, 0, 3'd0, 0);
    rdq(32'h0000_0F4B, 1, 3'd0, 0);
    iord(32'h0000_0105, 0);
    step(3'd0, 0, 0, 0, 0, 0, "R9");
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule